// File: doc/BRIEF.md
# Four-Operation Multi-Cycle ALU

This block is a small clocked arithmetic unit. It takes two unsigned operands, a two-bit operation code and a one-cycle start pulse, and returns a wide result a fixed number of clock edges later. It supports four operations: addition with carry-out, full-width multiplication, bitwise OR and bitwise AND. Bits of the result bus that an operation does not produce are driven to zero.

A caller raises the start pulse for one cycle with the operation and operands set up. It then reads the result after the fixed latency. The result bus holds its value until a later start pulse brings a new result through. A start pulse that arrives before the previous result has been read starts a second operation through the same pipeline. That operation comes out with the same latency, one cycle behind the first.

The operand width and the post-capture latency are parameters. A parameter also selects between a native multiplier and an unrolled shift-and-add array.

Top module: `quad_op_alu`

## Requirements
- R1: After power-up, and before any start pulse, the result bus reads zero.
- R2: The operation code and operands are sampled only on the rising edge at which the start input is high; values applied at any other time have no effect on that operation's result.
- R3: The result of an operation appears on the bus exactly two rising edges after its capture edge; after only one further edge the bus still shows the previous value.
- R4: Operation code 0 (add) gives the 9-bit unsigned sum, with the carry in bit 8 and bits 15:9 at zero.
- R5: Operation code 1 (multiply) gives the full 16-bit unsigned product.
- R6: Operation code 2 (OR) gives the bitwise OR in bits 7:0, with bits 15:8 at zero.
- R7: Operation code 3 (AND) gives the bitwise AND in bits 7:0, with bits 15:8 at zero.
- R8: While no start pulse is captured, the result bus keeps its last value, whatever the operation and operand inputs do.
- R9: Start pulses on consecutive cycles each produce their own result with the same latency, so the bus shows the older result first and the newest one a cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| op_start | input | 1 | One-cycle pulse that captures the operation and operands |
| op_sel | input | 2 | Operation code: 0 add, 1 multiply, 2 OR, 3 AND |
| opnd_a | input | 8 | First unsigned operand |
| opnd_b | input | 8 | Second unsigned operand |
| result | output | 16 | Result of the most recently completed operation |

## Verification
Clocked properties check the numeric result on every cycle. Whenever a start was captured the set latency ago, the sum or product on the bus must match the operands captured then. A logic result must show zeros in its upper byte. The bus must not change unless a capture falls exactly at that latency. The power-up value and the intermediate value one edge after capture can only be seen in the bench's scenarios. So can inputs that change after capture, long idle stretches and back-to-back pulses, each checked against expected values the bench computes itself.

// File: rtl/quad_op_alu_pkg.sv
package quad_op_alu_pkg;

   typedef enum logic [1:0] {
      OP_SUM  = 2'd0,
      OP_PROD = 2'd1,
      OP_IOR  = 2'd2,
      OP_CONJ = 2'd3
   } alu_op_e;

endpackage : quad_op_alu_pkg

// File: rtl/quad_op_capture.sv
module quad_op_capture
   import quad_op_alu_pkg::*;
#(
   parameter int OPND_W = 8
) (
   input  logic              clk,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [OPND_W-1:0] a_i,
   input  logic [OPND_W-1:0] b_i,
   output alu_op_e           op_q,
   output logic [OPND_W-1:0] a_q,
   output logic [OPND_W-1:0] b_q,
   output logic              fire_q
);

   alu_op_e           op_r   = OP_SUM;
   logic [OPND_W-1:0] a_r    = '0;
   logic [OPND_W-1:0] b_r    = '0;
   logic              fire_r = 1'b0;

   always_ff @(posedge clk) begin
      fire_r <= start_i;
      if (start_i) begin
         op_r <= alu_op_e'(op_i);
         a_r  <= a_i;
         b_r  <= b_i;
      end
   end

   assign op_q   = op_r;
   assign a_q    = a_r;
   assign b_q    = b_r;
   assign fire_q = fire_r;

endmodule : quad_op_capture

// File: rtl/quad_op_exec.sv
module quad_op_exec
   import quad_op_alu_pkg::*;
#(
   parameter int OPND_W     = 8,
   parameter bit NATIVE_MUL = 1'b1,
   localparam int RES_W     = 2 * OPND_W,
   localparam int SUM_W     = OPND_W + 1
) (
   input  alu_op_e           op_i,
   input  logic [OPND_W-1:0] a_i,
   input  logic [OPND_W-1:0] b_i,
   output logic [RES_W-1:0]  res_o
);

   logic [RES_W-1:0] prod;
   logic [SUM_W-1:0] sum;

   assign sum = SUM_W'(a_i) + SUM_W'(b_i);

   generate
      if (NATIVE_MUL) begin : g_mul_native
         assign prod = RES_W'(a_i) * RES_W'(b_i);
      end else begin : g_mul_shift
         logic [OPND_W:0][RES_W-1:0] acc;
         assign acc[0] = '0;
         for (genvar i = 0; i < OPND_W; i++) begin : g_row
            assign acc[i+1] = acc[i] +
                              (b_i[i] ? (RES_W'(a_i) << i) : RES_W'(0));
         end
         assign prod = acc[OPND_W];
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_SUM:  res_o = RES_W'(sum);
         OP_PROD: res_o = prod;
         OP_IOR:  res_o = RES_W'(a_i | b_i);
         OP_CONJ: res_o = RES_W'(a_i & b_i);
         default: res_o = '0;
      endcase
   end

endmodule : quad_op_exec

// File: rtl/quad_op_pipe.sv
module quad_op_pipe #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2,
   localparam int DEPTH = STAGES - 1
) (
   input  logic             clk,
   input  logic             vld_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] res_o
);

   logic             tail_vld;
   logic [WIDTH-1:0] tail_data;
   logic [WIDTH-1:0] res_r = '0;

   generate
      if (DEPTH == 0) begin : g_direct
         assign tail_vld  = vld_i;
         assign tail_data = data_i;
      end else begin : g_chain
         logic [DEPTH-1:0]            vld_q = '0;
         logic [DEPTH-1:0][WIDTH-1:0] dat_q = '0;
         always_ff @(posedge clk) begin
            vld_q[0] <= vld_i;
            dat_q[0] <= data_i;
            for (int i = 1; i < DEPTH; i++) begin
               vld_q[i] <= vld_q[i-1];
               dat_q[i] <= dat_q[i-1];
            end
         end
         assign tail_vld  = vld_q[DEPTH-1];
         assign tail_data = dat_q[DEPTH-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (tail_vld) res_r <= tail_data;
   end

   assign res_o = res_r;

endmodule : quad_op_pipe

// File: rtl/quad_op_alu.sv
module quad_op_alu
   import quad_op_alu_pkg::*;
#(
   parameter int OPND_W     = 8,
   parameter int STAGES     = 2,
   parameter bit NATIVE_MUL = 1'b1,
   localparam int RES_W     = 2 * OPND_W,
   localparam int SUM_W     = OPND_W + 1,
   localparam int LOOK      = STAGES + 1
) (
   input  logic              clk,
   input  logic              op_start,
   input  logic [1:0]        op_sel,
   input  logic [OPND_W-1:0] opnd_a,
   input  logic [OPND_W-1:0] opnd_b,
   output logic [RES_W-1:0]  result
);

   initial begin
      param_width_chk : assert (OPND_W >= 2 && OPND_W <= 32)
         else $error("OPND_W out of range");
      param_stages_chk : assert (STAGES >= 1 && STAGES <= 8)
         else $error("STAGES out of range");
   end

   alu_op_e           cap_op;
   logic [OPND_W-1:0] cap_a;
   logic [OPND_W-1:0] cap_b;
   logic              cap_fire;
   logic [RES_W-1:0]  exec_res;

   quad_op_capture #(.OPND_W(OPND_W)) u_capture (
      .clk     (clk),
      .start_i (op_start),
      .op_i    (op_sel),
      .a_i     (opnd_a),
      .b_i     (opnd_b),
      .op_q    (cap_op),
      .a_q     (cap_a),
      .b_q     (cap_b),
      .fire_q  (cap_fire)
   );

   quad_op_exec #(.OPND_W(OPND_W), .NATIVE_MUL(NATIVE_MUL)) u_exec (
      .op_i  (cap_op),
      .a_i   (cap_a),
      .b_i   (cap_b),
      .res_o (exec_res)
   );

   quad_op_pipe #(.WIDTH(RES_W), .STAGES(STAGES)) u_pipe (
      .clk    (clk),
      .vld_i  (cap_fire),
      .data_i (exec_res),
      .res_o  (result)
   );

   // Edge counter since power-up; keeps the look-back properties quiet
   // until enough history exists.
   logic [3:0] warm_q = '0;
   always_ff @(posedge clk) begin
      if (warm_q != 4'hF) warm_q <= warm_q + 4'd1;
   end

   // R4 R3
   sum_value_chk : assert property (@(posedge clk) disable iff (warm_q <= 4'(LOOK))
      ($past(op_start, LOOK) && $past(op_sel, LOOK) == OP_SUM) |->
      (result == RES_W'(SUM_W'($past(opnd_a, LOOK)) + SUM_W'($past(opnd_b, LOOK)))));

   // R5 R3
   prod_value_chk : assert property (@(posedge clk) disable iff (warm_q <= 4'(LOOK))
      ($past(op_start, LOOK) && $past(op_sel, LOOK) == OP_PROD) |->
      (result == RES_W'(RES_W'($past(opnd_a, LOOK)) * RES_W'($past(opnd_b, LOOK)))));

   // R6 R7
   logic_upper_chk : assert property (@(posedge clk) disable iff (warm_q <= 4'(LOOK))
      ($past(op_start, LOOK) && $past(op_sel[1], LOOK)) |->
      (result[RES_W-1:OPND_W] == '0));

   // R8
   hold_result_chk : assert property (@(posedge clk) disable iff (warm_q <= 4'(LOOK))
      !$past(op_start, LOOK) |-> $stable(result));

endmodule : quad_op_alu

// File: tb/quad_op_alu_test.sv
module quad_op_alu_test;

   logic        clk = 1'b0;
   logic        op_start = 1'b0;
   logic [1:0]  op_sel = 2'd0;
   logic [7:0]  opnd_a = 8'd0;
   logic [7:0]  opnd_b = 8'd0;
   logic [15:0] result;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   quad_op_alu uut (
      .clk      (clk),
      .op_start (op_start),
      .op_sel   (op_sel),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .result   (result)
   );

   always #4ns clk = ~clk;

   function automatic logic [15:0] model(input logic [1:0] op,
                                         input logic [7:0] a,
                                         input logic [7:0] b);
      case (op)
         2'd0:    return {7'd0, {1'b0, a} + {1'b0, b}};
         2'd1:    return 16'(a) * 16'(b);
         2'd2:    return {8'd0, a | b};
         default: return {8'd0, a & b};
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drives a one-cycle start; returns at the falling edge after capture.
   task automatic issue(input logic [1:0] op, input logic [7:0] a,
                        input logic [7:0] b);
      @(negedge clk);
      op_start = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
      @(negedge clk);
      op_start = 1'b0;
   endtask

   task automatic scramble();
      op_sel = 2'($urandom); opnd_a = 8'($urandom); opnd_b = 8'($urandom);
   endtask

   task automatic run_op(input string tag, input logic [1:0] op,
                         input logic [7:0] a, input logic [7:0] b);
      logic [15:0] prev;
      prev = result;
      issue(op, a, b);
      scramble();                 // R2: post-capture inputs must not matter
      @(negedge clk);
      check({tag, " R3 one edge"}, result, prev);
      scramble();
      @(negedge clk);
      check(tag, result, model(op, a, b));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      check("R1 power-up", result, 16'h0000);
      repeat (3) @(negedge clk);
      check("R1 idle", result, 16'h0000);

      run_op("R4 add carry", 2'd0, 8'hFF, 8'hFF);
      check("R4 bit8", {15'd0, result[8]}, 16'd1);
      run_op("R4 add zero", 2'd0, 8'h00, 8'h00);
      run_op("R5 mul max", 2'd1, 8'hFF, 8'hFF);
      run_op("R5 mul one", 2'd1, 8'h01, 8'hA5);
      run_op("R6 or", 2'd2, 8'hF0, 8'h0F);
      run_op("R7 and", 2'd3, 8'hFF, 8'h3C);
      run_op("R2 capture", 2'd1, 8'd13, 8'd17);

      // R8: long idle with wandering inputs
      for (int k = 0; k < 20; k++) begin
         scramble();
         @(negedge clk);
         check("R8 hold", result, 16'(13 * 17));
      end

      // R9: back-to-back starts
      @(negedge clk);
      op_start = 1'b1; op_sel = 2'd1; opnd_a = 8'd200; opnd_b = 8'd3;
      @(negedge clk);
      op_sel = 2'd0; opnd_a = 8'd250; opnd_b = 8'd9;
      @(negedge clk);
      op_start = 1'b0; scramble();
      @(negedge clk);
      check("R9 first", result, 16'd600);
      @(negedge clk);
      check("R9 newest", result, 16'd259);
      @(negedge clk);
      check("R9 settle", result, 16'd259);

      // Constrained random mix
      for (int n = 0; n < 300; n++) begin
         logic [1:0] op;
         logic [7:0] a, b;
         op = 2'($urandom);
         a  = 8'($urandom);
         b  = 8'($urandom);
         if (n % 7 == 0) a = 8'hFF;
         if (n % 11 == 0) b = 8'h00;
         case (op)
            2'd0:    run_op("R4 random", op, a, b);
            2'd1:    run_op("R5 random", op, a, b);
            2'd2:    run_op("R6 random", op, a, b);
            default: run_op("R7 random", op, a, b);
         endcase
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8ns * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule : quad_op_alu_test